// File: doc/BRIEF.md
# Dual-Lane Programmable Delay Line

The block delays two 4-bit data lanes by a programmable number of clock cycles. The lanes are carried on one 8-bit bus: bits 3:0 form the low lane and bits 7:4 the high lane. Both lanes share the clock, the 4-bit length code and the mode bit. Each lane pushes its input through a chain of seventeen registers. A tap multiplexer picks one of stages 2 to 17 and loads it into a dedicated output register. The result is a delay of 3 to 18 cycles.

The length code and the mode bit are sampled into a control register on every rising edge, and the multiplexers steer from that registered copy. With the mode bit low, both lanes follow the code. With it high, the high lane is held at the full 18-cycle delay while the low lane stays programmable. Control changes only re-steer the multiplexers. The chain stages are never reset or flushed, so data already in flight is kept. A synchronous reset clears only the control register.

Top module: `twin_delay_line`

## Requirements
- R1: With mode 0 and length code n (0..15), a data value sampled on edge e appears on both lane outputs after edge e+n+2, a delay of n+3 cycles.
- R2: Code 0 gives the shortest delay of 3 cycles and code 15 gives the longest delay of 18 cycles.
- R3: Bits 3:0 of data_i reach only bits 3:0 of data_o, and bits 7:4 reach only bits 7:4, so the two lanes can carry different delays at the same time.
- R4: With mode 1 (hold_hi_i = 1), the high lane is delayed by 18 cycles whatever the length code.
- R5: With mode 1, the low lane still takes the delay of n+3 cycles selected by the length code.
- R6: Length code and mode are registered. A value sampled on edge k steers the output register from edge k+1 on, and the output after edge k still comes from the previous tap.
- R7: Changing the length code or mode, at any rate, leaves the contents of chain stages 1 to 17 unchanged. After any change the output equals the input history delayed by the newly selected amount.
- R8: While rst is high on an edge, the control register loads code 0 and mode 0 regardless of the control inputs. The chain stages are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| rst | input | 1 | Synchronous reset of the control register only |
| len_code_i | input | 4 | Length code n; delay is n+3 cycles |
| hold_hi_i | input | 1 | Mode: 1 pins the high lane at 18 cycles |
| data_i | input | 8 | Lane inputs: [3:0] low lane, [7:4] high lane |
| data_o | output | 8 | Lane outputs with the same bit split |

## Verification
The bench builds the block with its default 4-bit lane width and 4-bit length code. This covers all sixteen taps, from the 3-cycle minimum to the 18-cycle maximum, and the mode split between the two nibbles. A history model in the bench indexes past inputs by the registered control values. This lets it follow code and mode changes made every few cycles in the middle of a stream, and check that data already in the chain survives them. Holding reset while the control inputs request the longest delay shows that reset forces the 3-cycle path without disturbing the chain.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    // Width of the length code; the tap count follows from it.
    localparam int CODE_W   = 4;
    localparam int NUM_TAPS = 2 ** CODE_W;
    // Stage 1 feeds stage 2, taps span stages 2..STAGES.
    localparam int STAGES   = NUM_TAPS + 1;
    localparam int MIN_DLY  = 3;
    localparam int MAX_DLY  = STAGES + 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              fix;
    } ctrl_t;
endpackage

// File: rtl/tdl_ctrl_reg.sv
module tdl_ctrl_reg
    import tdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              fix_i,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (rst) begin
            ctrl_d = '0;
        end else begin
            ctrl_d.code = code_i;
            ctrl_d.fix  = fix_i;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tdl_tap_pick.sv
module tdl_tap_pick
    import tdl_pkg::*;
#(
    parameter bit FIXABLE = 1'b0
) (
    input  ctrl_t             ctrl_i,
    output logic [CODE_W-1:0] sel_o
);
    // A fixable lane jumps to the last tap when the mode bit is set.
    always_comb begin
        if (FIXABLE && ctrl_i.fix) begin
            sel_o = '1;
        end else begin
            sel_o = ctrl_i.code;
        end
    end
endmodule

// File: rtl/tdl_lane.sv
module tdl_lane
    import tdl_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic [LANE_W-1:0] din_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic [LANE_W-1:0] dout_o,
    output logic [LANE_W-1:0] tail_o
);
    localparam int IDX_W = $clog2(STAGES);

    typedef struct packed {
        logic [STAGES-1:0][LANE_W-1:0] chain;
        logic [LANE_W-1:0]             out;
    } lane_st_t;

    lane_st_t          st_d, st_q;
    logic [IDX_W-1:0]  tap_idx;

    // Select value s addresses stage s+2, which sits at chain index s+1.
    assign tap_idx = IDX_W'(sel_i) + IDX_W'(1);

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.out = st_q.chain[tap_idx];
    end

    // Data path carries no reset; contents are undefined until filled.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout_o = st_q.out;
    assign tail_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/twin_delay_line.sv
module twin_delay_line
    import tdl_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CODE_W-1:0]     len_code_i,
    input  logic                  hold_hi_i,
    input  logic [2*LANE_W-1:0]   data_i,
    output logic [2*LANE_W-1:0]   data_o
);
    localparam int NUM_LANES = 2;

    ctrl_t                              ctrl_q;
    logic [NUM_LANES-1:0][LANE_W-1:0]   tail_w;

    tdl_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .code_i (len_code_i),
        .fix_i  (hold_hi_i),
        .ctrl_o (ctrl_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [CODE_W-1:0] sel_w;

        // Only the upper lane may be pinned at full length.
        tdl_tap_pick #(
            .FIXABLE (g == NUM_LANES - 1)
        ) u_pick (
            .ctrl_i (ctrl_q),
            .sel_o  (sel_w)
        );

        tdl_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .clk    (clk),
            .din_i  (data_i[g*LANE_W +: LANE_W]),
            .sel_i  (sel_w),
            .dout_o (data_o[g*LANE_W +: LANE_W]),
            .tail_o (tail_w[g])
        );
    end
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker
    import tdl_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [2*LANE_W-1:0]         data_i,
    input logic [2*LANE_W-1:0]         data_o,
    input ctrl_t                       ctrl_q,
    input logic [1:0][LANE_W-1:0]      tail_w
);
    // Edges seen since time zero; gates checks until the chain is filled.
    logic [5:0] warm_q = '0;
    logic       warm;

    always_ff @(posedge clk) begin
        if (warm_q != '1) begin
            warm_q <= warm_q + 6'd1;
        end
    end

    assign warm = (warm_q >= 6'(MAX_DLY + 2));

    // R2 / R1: code 0 gives three cycles on the low lane
    assert_min_delay_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ctrl_q.code) == '0)
        |-> data_o[LANE_W-1:0] == $past(data_i[LANE_W-1:0], 3));

    // R1: with mode 0 the high lane follows the same short path
    assert_min_delay_hi_R1: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ctrl_q.code) == '0 && !$past(ctrl_q.fix))
        |-> data_o[2*LANE_W-1:LANE_W] == $past(data_i[2*LANE_W-1:LANE_W], 3));

    // R4: pinned high lane loads from the last chain stage
    assert_fixed_high_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ctrl_q.fix))
        |-> data_o[2*LANE_W-1:LANE_W] == $past(tail_w[1]));

    // R2: code 15 loads the low lane from the last chain stage
    assert_max_tap_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ctrl_q.code) == '1)
        |-> data_o[LANE_W-1:0] == $past(tail_w[0]));

    // R8: reset leaves the control register at code 0, mode 0
    assert_reset_ctrl_R8: assert property (@(posedge clk)
        (warm && $past(rst)) |-> (ctrl_q.code == '0 && !ctrl_q.fix));
endmodule

bind twin_delay_line tdl_checker #(
    .LANE_W (LANE_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .data_i (data_i),
    .data_o (data_o),
    .ctrl_q (ctrl_q),
    .tail_w (tail_w)
);

// File: tb/twin_delay_line_tb_top.sv
`timescale 1ns/1ps
module twin_delay_line_tb_top;
    localparam int HIST = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] len_code_i = 4'd0;
    logic       hold_hi_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] din_h  [HIST];
    logic [3:0] code_h [HIST];
    logic       mode_h [HIST];

    always #4 clk = ~clk;

    twin_delay_line dut_i (
        .clk        (clk),
        .rst        (rst),
        .len_code_i (len_code_i),
        .hold_hi_i  (hold_hi_i),
        .data_i     (data_i),
        .data_o     (data_o)
    );

    // History of what each edge sampled, controls as the register sees them.
    always @(posedge clk) begin
        din_h[cyc % HIST]  <= data_i;
        code_h[cyc % HIST] <= rst ? 4'd0 : len_code_i;
        mode_h[cyc % HIST] <= rst ? 1'b0 : hold_hi_i;
        cyc <= cyc + 1;
    end

    task automatic compare(input string tag, input string lane,
                           input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s lane at edge %0d: actual %h expected %h",
                     tag, lane, cyc - 1, act, exp);
        end
    endtask

    // Called just after a falling edge: output reflects the load at edge e.
    task automatic check_now(input string tag);
        int e, s_lo, s_hi;
        logic [3:0] c;
        logic       m;
        e = cyc - 1;
        if (e < 1) return;
        c = code_h[(e - 1) % HIST];
        m = mode_h[(e - 1) % HIST];
        s_lo = int'(c) + 2;
        s_hi = m ? 17 : int'(c) + 2;
        if (e - s_lo >= 0)
            compare(tag, "low", data_o[3:0], din_h[(e - s_lo) % HIST][3:0]);
        if (e - s_hi >= 0)
            compare(tag, "high", data_o[7:4], din_h[(e - s_hi) % HIST][7:4]);
    endtask

    task automatic run_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now(tag);
            data_i = 8'($urandom);
        end
    endtask

    task automatic set_ctrl(input logic [3:0] code, input logic mode);
        @(negedge clk);
        check_now("R6");
        len_code_i = code;
        hold_hi_i  = mode;
        data_i     = 8'($urandom);
    endtask

    // R8: reset overrides requests for the longest delay and pinning
    task automatic t_reset_controls();
        rst = 1'b1;
        len_code_i = 4'd15;
        hold_hi_i  = 1'b1;
        run_cycles(30, "R8");
        rst = 1'b0;
        run_cycles(25, "R8 R7");
    endtask

    // R1 R2: every code with mode 0
    task automatic t_code_sweep();
        for (int c = 0; c < 16; c++) begin
            set_ctrl(4'(c), 1'b0);
            run_cycles(22, (c == 0 || c == 15) ? "R2" : "R1");
        end
    endtask

    // R4 R5: high lane pinned while the low lane follows the code
    task automatic t_fixed_high();
        set_ctrl(4'd0, 1'b1);
        run_cycles(24, "R4 R5");
        set_ctrl(4'd7, 1'b1);
        run_cycles(24, "R4 R5");
        set_ctrl(4'd15, 1'b1);
        run_cycles(24, "R4");
    endtask

    // R3: lanes carry independent patterns and delays
    task automatic t_lane_split();
        set_ctrl(4'd2, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check_now("R3");
            data_i = {4'(i % 3 == 0 ? 4'hA : 4'h5), 4'(i)};
        end
    endtask

    // R6 R7: frequent control changes mid-stream
    task automatic t_live_changes();
        for (int k = 0; k < 60; k++) begin
            set_ctrl(4'($urandom), 1'($urandom));
            run_cycles(1 + int'($urandom % 4), "R6 R7");
        end
        set_ctrl(4'd15, 1'b0);
        run_cycles(3, "R7");
        set_ctrl(4'd0, 1'b0);
        run_cycles(3, "R7");
        set_ctrl(4'd15, 1'b0);
        run_cycles(20, "R7");
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired at edge %0d: actual running expected done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_controls();
        t_code_sweep();
        t_fixed_high();
        t_lane_split();
        t_live_changes();
        t_reset_controls();
        run_cycles(5, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule